// File: doc/BRIEF.md
# Periodic Resistance Detection Scheduler

This block sequences a moisture or foreign-object check on one connector pin. When software sets the enable bit, the block checks the pin-select code. If the code names a real pin, the block forces that pin's signal switch open and sends a one-cycle start pulse to an external measurement engine. It then waits for the engine's done pulse and 8-bit code. The analog measurement itself lies outside the block.

When the engine reports, the block keeps the code as the result and compares it with a programmable threshold. It raises a completion flag and, if needed, a low-resistance flag. It then either stops or waits a chosen number of millisecond ticks and measures again. A low reading clears the enable bit, so detection stops without software action. Both flags clear on read, and each has its own mask before it reaches the interrupt line.

Top module: `rdet_sched`

## Requirements
- R1: After reset the result is 0xFF, enable is 0, both flags and the interrupt are 0, no switch is forced open and no start is issued.
- R2: With enable set and a valid pin code (001 DP_R, 010 DN_L, 011 SBU1, 100 SBU2), the cycle after enable is set a single-cycle start pulse appears. It carries that pin code. The override bit for that pin (bit 0 DP_R, bit 1 DN_L, bit 2 SBU1, bit 3 SBU2) stays high until the done pulse.
- R3: Pin codes 000 and 101 to 111 at enable time issue no start and force no switch open, and they clear enable one cycle later.
- R4: A done pulse stores the engine code as the result in the following cycle, and the switch override drops in that same cycle. The result does not change at any other time.
- R5: Every accepted done pulse sets the completion flag.
- R6: The low-resistance flag is set only when the code is strictly below the threshold. A code equal to the threshold does not set it.
- R7: A low-resistance result clears enable, and no further measurement starts.
- R8: With interval code 00 a single measurement runs, and enable clears when it finishes.
- R9: With interval codes 01, 10 and 11, the next start pulse comes exactly N x TICK_CYC cycles after the done pulse. N is MS_SHORT, MS_MID or MS_LONG respectively.
- R10: Clearing enable during the wait between measurements cancels the pending measurement.
- R11: A read-clear pulse clears both flags. When a set and a clear fall in the same cycle, the set wins.
- R12: The interrupt is high when any flag is set whose mask bit is 0.
- R13: The range bit in force at the first start is passed to the engine and kept for the repeated measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_val_i | input | 1 | Value written to the enable bit |
| pin_sel_i | input | 3 | Pin to measure |
| range_i | input | 1 | Measurement scale select |
| intv_i | input | 2 | Repeat interval code |
| thresh_i | input | 8 | Low-resistance threshold |
| rd_clr_i | input | 1 | Read-clear strobe for both flags |
| mask_done_i | input | 1 | Masks the completion flag from the interrupt |
| mask_low_i | input | 1 | Masks the low-resistance flag from the interrupt |
| meas_done_i | input | 1 | Engine done pulse |
| meas_code_i | input | 8 | Engine result code |
| meas_start_o | output | 1 | Start pulse to the engine |
| meas_pin_o | output | 3 | Pin code for the engine |
| meas_range_o | output | 1 | Scale select for the engine |
| sw_open_o | output | 4 | Per-pin switch-open override |
| en_o | output | 1 | Current enable bit |
| result_o | output | 8 | Last stored result |
| done_flag_o | output | 1 | Completion flag |
| low_flag_o | output | 1 | Low-resistance flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench drives single-shot runs and repeated runs at three interval codes, and it checks the gap between done and the next start against the tick count for each code. Result codes above, equal to and below the threshold separate a strict from an inclusive comparison and show the automatic disarm. Invalid pin codes at both ends of the illegal range show that the start is refused. A clear of enable during a wait, and a read-clear that lands on a setting edge, exercise the cancel and priority paths. A behavioural model checks every output on every cycle.

// File: rtl/rdet_pkg.sv
package rdet_pkg;

    localparam int CODE_W = 8;
    localparam int PIN_W  = 3;
    localparam int N_PINS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        IV_ONCE  = 2'b00,
        IV_SHORT = 2'b01,
        IV_MID   = 2'b10,
        IV_LONG  = 2'b11
    } intv_e;

    typedef struct packed {
        logic [PIN_W-1:0] pin;
        logic             rng;
    } meas_cfg_t;

    function automatic logic pin_ok(input logic [PIN_W-1:0] code);
        return (code >= 3'd1) && (code <= 3'd4);
    endfunction

    function automatic logic [N_PINS-1:0] pin_mask(input logic [PIN_W-1:0] code);
        logic [N_PINS-1:0] m;
        m = '0;
        if (pin_ok(code)) m[code - 3'd1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rdet_timer.sv
module rdet_timer #(
    parameter int TICK_CYC = 100000,
    parameter int MS_SHORT = 100,
    parameter int MS_MID   = 1000,
    parameter int MS_LONG  = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] intv,
    input  logic       run,
    output logic       expire
);
    import rdet_pkg::*;

    localparam int PRE_W = $clog2(TICK_CYC + 1);
    localparam int MS_W  = $clog2(MS_LONG + 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic [MS_W-1:0]  tgt_q;
    logic [MS_W-1:0]  tgt_sel;
    logic             tick;

    always_comb begin
        case (intv_e'(intv))
            IV_SHORT: tgt_sel = MS_W'(MS_SHORT);
            IV_MID:   tgt_sel = MS_W'(MS_MID);
            IV_LONG:  tgt_sel = MS_W'(MS_LONG);
            default:  tgt_sel = MS_W'(1);
        endcase
    end

    assign tick   = run && (pre_q == PRE_W'(TICK_CYC - 1));
    assign expire = tick && (ms_q == tgt_q - MS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            ms_q  <= '0;
            tgt_q <= MS_W'(1);
        end else if (load) begin
            pre_q <= '0;
            ms_q  <= '0;
            tgt_q <= tgt_sel;
        end else if (run) begin
            if (tick) begin
                pre_q <= '0;
                ms_q  <= ms_q + MS_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    // R9: the millisecond count never passes the interval length
    p_ms_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |-> (ms_q < tgt_q));

endmodule

// File: rtl/rdet_seq.sv
module rdet_seq
    import rdet_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_wr,
    input  logic                 en_val,
    input  logic [PIN_W-1:0]     pin_sel,
    input  logic                 rng,
    input  logic [1:0]           intv,
    input  logic                 meas_done,
    input  logic                 meas_low,
    input  logic                 expire,
    output logic                 en_o,
    output logic                 start_o,
    output logic                 load_o,
    output logic                 run_o,
    output logic                 accept_o,
    output meas_cfg_t            cfg_o,
    output logic [N_PINS-1:0]    sw_open_o
);
    seq_st_e   st_q, st_n;
    logic      en_q;
    logic      start_q;
    logic      go;
    logic      clr_en;
    meas_cfg_t cfg_q;

    always_comb begin
        st_n   = st_q;
        go     = 1'b0;
        clr_en = 1'b0;
        load_o = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (en_q) begin
                    if (pin_ok(pin_sel)) begin
                        st_n = ST_MEAS;
                        go   = 1'b1;
                    end else begin
                        clr_en = 1'b1;
                    end
                end
            end
            ST_MEAS: begin
                if (meas_done) begin
                    if (meas_low || intv_e'(intv) == IV_ONCE) begin
                        clr_en = 1'b1;
                        st_n   = ST_IDLE;
                    end else if (!en_q) begin
                        st_n = ST_IDLE;
                    end else begin
                        st_n   = ST_WAIT;
                        load_o = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!en_q) begin
                    st_n = ST_IDLE;
                end else if (expire) begin
                    st_n = ST_MEAS;
                    go   = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            en_q    <= 1'b0;
            start_q <= 1'b0;
            cfg_q   <= '{pin: 3'b001, rng: 1'b0};
        end else begin
            st_q    <= st_n;
            start_q <= go;
            if (go && st_q == ST_IDLE) cfg_q <= '{pin: pin_sel, rng: rng};
            if (en_wr)       en_q <= en_val;
            else if (clr_en) en_q <= 1'b0;
        end
    end

    assign en_o      = en_q;
    assign start_o   = start_q;
    assign run_o     = (st_q == ST_WAIT);
    assign accept_o  = (st_q == ST_MEAS) && meas_done;
    assign cfg_o     = cfg_q;
    assign sw_open_o = (st_q == ST_MEAS) ? pin_mask(cfg_q.pin) : '0;

    // R2: start is a single-cycle pulse
    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);
    // R2: at most one pin is forced open
    p_open_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_open_o));
    // R3: an invalid pin code never launches a measurement
    p_bad_pin_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && en_q && !pin_ok(pin_sel) && !en_wr) |=> (!en_o && !start_o));
    // R7: a low reading disarms detection
    p_low_disarm_r7: assert property (@(posedge clk) disable iff (rst)
        (accept_o && meas_low && !en_wr) |=> !en_o);
    // R10: a cleared enable in the wait state yields no start
    p_cancel_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && !en_q) |=> !start_o);

endmodule

// File: rtl/rdet_flags.sv
module rdet_flags
    import rdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [CODE_W-1:0] code,
    input  logic              low,
    input  logic              rd_clr,
    input  logic              mask_done,
    input  logic              mask_low,
    output logic [CODE_W-1:0] result_o,
    output logic              done_flag_o,
    output logic              low_flag_o,
    output logic              irq_o
);
    logic [CODE_W-1:0] res_q;
    logic              done_q;
    logic              low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '1;
            done_q <= 1'b0;
            low_q  <= 1'b0;
        end else begin
            if (accept) res_q <= code;
            if (accept)      done_q <= 1'b1;
            else if (rd_clr) done_q <= 1'b0;
            if (accept && low) low_q <= 1'b1;
            else if (rd_clr)   low_q <= 1'b0;
        end
    end

    assign result_o    = res_q;
    assign done_flag_o = done_q;
    assign low_flag_o  = low_q;
    assign irq_o       = (done_q && !mask_done) || (low_q && !mask_low);

    // R4: the result only moves on an accepted done
    p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(result_o));
    // R5: every accepted done raises the completion flag
    p_done_set_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> done_flag_o);
    // R11: a read-clear with no new result empties both flags
    p_rd_clr_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !accept) |=> (!done_flag_o && !low_flag_o));

endmodule

// File: rtl/rdet_sched.sv
module rdet_sched #(
    parameter int TICK_CYC = 100000,
    parameter int MS_SHORT = 100,
    parameter int MS_MID   = 1000,
    parameter int MS_LONG  = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_wr_i,
    input  logic       en_val_i,
    input  logic [2:0] pin_sel_i,
    input  logic       range_i,
    input  logic [1:0] intv_i,
    input  logic [7:0] thresh_i,
    input  logic       rd_clr_i,
    input  logic       mask_done_i,
    input  logic       mask_low_i,
    input  logic       meas_done_i,
    input  logic [7:0] meas_code_i,
    output logic       meas_start_o,
    output logic [2:0] meas_pin_o,
    output logic       meas_range_o,
    output logic [3:0] sw_open_o,
    output logic       en_o,
    output logic [7:0] result_o,
    output logic       done_flag_o,
    output logic       low_flag_o,
    output logic       irq_o
);
    import rdet_pkg::*;

    logic      meas_low;
    logic      load;
    logic      run;
    logic      expire;
    logic      accept;
    meas_cfg_t cfg;

    assign meas_low = (meas_code_i < thresh_i);

    rdet_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en_wr     (en_wr_i),
        .en_val    (en_val_i),
        .pin_sel   (pin_sel_i),
        .rng       (range_i),
        .intv      (intv_i),
        .meas_done (meas_done_i),
        .meas_low  (meas_low),
        .expire    (expire),
        .en_o      (en_o),
        .start_o   (meas_start_o),
        .load_o    (load),
        .run_o     (run),
        .accept_o  (accept),
        .cfg_o     (cfg),
        .sw_open_o (sw_open_o)
    );

    rdet_timer #(
        .TICK_CYC (TICK_CYC),
        .MS_SHORT (MS_SHORT),
        .MS_MID   (MS_MID),
        .MS_LONG  (MS_LONG)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .intv   (intv_i),
        .run    (run),
        .expire (expire)
    );

    rdet_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .code        (meas_code_i),
        .low         (meas_low),
        .rd_clr      (rd_clr_i),
        .mask_done   (mask_done_i),
        .mask_low    (mask_low_i),
        .result_o    (result_o),
        .done_flag_o (done_flag_o),
        .low_flag_o  (low_flag_o),
        .irq_o       (irq_o)
    );

    assign meas_pin_o   = cfg.pin;
    assign meas_range_o = cfg.rng;

    // R13: the scale seen by the engine is steady while a measurement runs
    p_range_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (sw_open_o != 4'b0) |=> $stable(meas_range_o) || meas_start_o);

endmodule

// File: tb/rdet_sched_test.sv
module rdet_sched_test;

    localparam int T  = 4;
    localparam int NS = 3;
    localparam int NM = 5;
    localparam int NL = 7;

    logic clk = 0;
    logic rst = 1;
    logic en_wr = 0, en_val = 0, rng = 0, rd_clr = 0, mk_done = 0, mk_low = 0, done = 0;
    logic [2:0] pin = 3'b001;
    logic [1:0] intv = 2'b00;
    logic [7:0] thr = 8'h16, code = 8'h00;

    logic       start, m_rng_o, en_o, dflag, lflag, irq;
    logic [2:0] m_pin_o;
    logic [3:0] sw_open;
    logic [7:0] result;

    int tests = 0, fails = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    rdet_sched #(.TICK_CYC(T), .MS_SHORT(NS), .MS_MID(NM), .MS_LONG(NL)) uut (
        .clk(clk), .rst(rst), .en_wr_i(en_wr), .en_val_i(en_val), .pin_sel_i(pin),
        .range_i(rng), .intv_i(intv), .thresh_i(thr), .rd_clr_i(rd_clr),
        .mask_done_i(mk_done), .mask_low_i(mk_low), .meas_done_i(done),
        .meas_code_i(code), .meas_start_o(start), .meas_pin_o(m_pin_o),
        .meas_range_o(m_rng_o), .sw_open_o(sw_open), .en_o(en_o),
        .result_o(result), .done_flag_o(dflag), .low_flag_o(lflag), .irq_o(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 measuring, 2 waiting
    int  md = 0, left = 0, r_res = 255, r_pin = 1;
    bit  r_en = 0, r_st = 0, r_d = 0, r_l = 0, r_rng = 0;

    function automatic int ms_of(input logic [1:0] c);
        return (c == 2'b01) ? NS : (c == 2'b10) ? NM : NL;
    endfunction

    always @(posedge clk) begin
        bit drop, nst;
        drop = 0; nst = 0;
        if (rst) begin
            md = 0; r_en = 0; r_st = 0; r_d = 0; r_l = 0; r_res = 255; r_pin = 1; r_rng = 0;
        end else begin
            if (rd_clr) begin r_d = 0; r_l = 0; end
            if (md == 0) begin
                if (r_en) begin
                    if (pin >= 1 && pin <= 4) begin
                        md = 1; nst = 1; r_pin = pin; r_rng = rng;
                    end else drop = 1;
                end
            end else if (md == 1) begin
                if (done) begin
                    r_res = code; r_d = 1;
                    if (code < thr) begin r_l = 1; drop = 1; md = 0; end
                    else if (intv == 2'b00) begin drop = 1; md = 0; end
                    else if (!r_en) md = 0;
                    else begin md = 2; left = ms_of(intv) * T; end
                end
            end else begin
                if (!r_en) md = 0;
                else begin
                    left--;
                    if (left == 0) begin md = 1; nst = 1; end
                end
            end
            r_st = nst;
            if (en_wr) r_en = en_val;
            else if (drop) r_en = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R2/R9 start", start, r_st);
            check("R2/R4 switch override", sw_open, md == 1 ? (1 << (r_pin - 1)) : 0);
            check("R4 result", result, r_res);
            check("R5/R11 completion flag", dflag, r_d);
            check("R6/R11 low flag", lflag, r_l);
            check("R12 irq", irq, (r_d && !mk_done) || (r_l && !mk_low));
            check("R3/R7/R8/R10 enable", en_o, r_en);
            if (start) begin
                check("R2 engine pin", m_pin_o, r_pin);
                check("R13 engine range", m_rng_o, r_rng);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic set_en(input logic v);
        en_wr = 1; en_val = v; step(); en_wr = 0;
    endtask

    task automatic finish_meas(input logic [7:0] c);
        code = c; done = 1; step(); done = 0;
    endtask

    task automatic to_start(output int n);
        n = 0;
        do begin step(); n++; end while (!start && n < 500);
    endtask

    task automatic count_starts(input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin step(); if (start) n++; end
    endtask

    initial begin
        int n;
        repeat (3) step();
        rst = 0;
        step();
        check("R1 reset result", result, 8'hFF);
        check("R1 reset enable", en_o, 0);
        check("R1 reset flags", {dflag, lflag, irq}, 0);
        check("R1 reset override", sw_open, 0);

        // single shot on DP_R, range 1
        pin = 3'b001; rng = 1; intv = 2'b00;
        set_en(1);
        to_start(n);
        check("R2 start one cycle after enable", n, 1);
        check("R2 DP_R override bit0", sw_open, 4'b0001);
        check("R13 range at start", m_rng_o, 1);
        rng = 0;
        step(); step();
        finish_meas(8'h40);
        check("R4 result stored", result, 8'h40);
        check("R4 override released", sw_open, 0);
        check("R5 completion set", dflag, 1);
        check("R6 no low above threshold", lflag, 0);
        check("R8 single shot clears enable", en_o, 0);
        count_starts(30, n);
        check("R8 no repeat", n, 0);
        check("R12 irq from completion", irq, 1);
        mk_done = 1; step();
        check("R12 masked completion", irq, 0);
        mk_done = 0;
        rd_clr = 1; step(); rd_clr = 0;
        check("R11 read-clear", dflag, 0);

        // invalid codes at both ends
        pin = 3'b000; set_en(1); step();
        check("R3 code 000 clears enable", en_o, 0);
        check("R3 code 000 no override", sw_open, 0);
        pin = 3'b101; set_en(1); count_starts(10, n);
        check("R3 code 101 no start", n, 0);
        check("R3 code 101 enable cleared", en_o, 0);

        // repeat at short interval on SBU1
        pin = 3'b011; intv = 2'b01; rng = 1;
        set_en(1); to_start(n);
        check("R2 SBU1 override bit2", sw_open, 4'b0100);
        rng = 0;
        finish_meas(8'h30);
        to_start(n);
        check("R9 short interval gap", n, NS * T);
        check("R13 range kept on repeat", m_rng_o, 1);
        step();
        code = 8'h16; done = 1; rd_clr = 1; step(); done = 0; rd_clr = 0;
        check("R11 set wins over clear", dflag, 1);
        check("R6 equal not low", lflag, 0);
        to_start(n);
        check("R9 short gap again", n, NS * T);
        finish_meas(8'h15);
        check("R6 below threshold is low", lflag, 1);
        check("R7 low clears enable", en_o, 0);
        mk_done = 1; step();
        check("R12 irq from low flag", irq, 1);
        mk_low = 1; step();
        check("R12 both masked", irq, 0);
        mk_done = 0; mk_low = 0;
        count_starts(40, n);
        check("R7 no measurement after low", n, 0);
        rd_clr = 1; step(); rd_clr = 0;

        // mid interval on DN_L
        pin = 3'b010; intv = 2'b10;
        set_en(1); to_start(n);
        check("R2 DN_L override bit1", sw_open, 4'b0010);
        finish_meas(8'hA0);
        to_start(n);
        check("R9 mid interval gap", n, NM * T);
        finish_meas(8'hA1);
        step(); step();
        set_en(0);
        count_starts(40, n);
        check("R10 cancel on mid wait", n, 0);

        // long interval on SBU2, cancel inside wait
        pin = 3'b100; intv = 2'b11;
        set_en(1); to_start(n);
        check("R2 SBU2 override bit3", sw_open, 4'b1000);
        finish_meas(8'h80);
        to_start(n);
        check("R9 long interval gap", n, NL * T);
        finish_meas(8'h81);
        repeat (5) step();
        set_en(0);
        count_starts(60, n);
        check("R10 cancel on long wait", n, 0);
        check("R10 override idle", sw_open, 0);

        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule